// File: doc/BRIEF.md
# Short I/O Bus Slave Register Interface

This block is the slave end of a 16-bit asynchronous backplane bus for a board with a 128-byte window in short I/O space. It takes the address lines, the address modifier and the two data strobes, along with the write line and the incoming data. It decides whether the access targets this board. If it does, it carries out the access and answers with an active-low data acknowledge. The acknowledge stays low until the master lifts both strobes.

Inside the window there are four kinds of location:

- a fixed identification word;
- one address that holds both control and status, split by access direction;
- a read-only converter data word;
- 32 channel words, which live in a shared RAM.

A channel access raises a request towards the RAM arbiter. It acknowledges only once the arbiter grants the slot. Some control bits are write-only strobes that pulse for a single clock. The data strobes pass through two flip-flops before any decision is made.

Top module: `sio_slave_if`

## Requirements
- R1: After reset, bus_dtack_n is 1, bus_dout_en is 0, ctrl_o and strobe_o are 0 and ram_req_o is 0.
- R2: An access is answered only if all of these hold: bus_as_n is 0, address bits 15..7 equal cfg_base, and bus_am is 6'h2D when cfg_nonpriv is 0 or 6'h29 when cfg_nonpriv is 1. Any other access gets no acknowledge and changes no output.
- R3: Reading word offset 0x00 returns 16'h1700, the ID byte 0x17 on bits 15..8. Offset 0x04 returns adc_data_i. Any other offset below 0x40 other than 0x02 reads as 0.
- R4: A write to offset 0x02 updates ctrl_o per byte lane, with strobe bit 1 (DS1) enabling bits 15..8 and strobe bit 0 (DS0) enabling bits 7..0. Bits in the strobe mask (default 16'hE000) are stored as 0. A read of offset 0x02 returns status_i.
- R5: A write to offset 0x02 drives the enabled-lane data bits inside the strobe mask onto strobe_o for exactly one clock.
- R6: Writes to offsets 0x00, 0x04 or an unmapped offset are acknowledged, and leave ctrl_o, strobe_o and the RAM port untouched.
- R7: An access to offset 0x40+2n addresses RAM word n (0..31). ram_req_o stays high until ram_rdy_i is sampled high, and the acknowledge is held off until then. A write passes its data and byte lanes on; a read returns ram_rdata_i as sampled at the grant.
- R8: Once both strobes are removed, bus_dtack_n returns to 1 within four clocks.
- R9: bus_dout_en is 1 only while a read is being acknowledged, never on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 9 | Base address compared with address bits 15..7 |
| cfg_nonpriv | input | 1 | 1 accepts nonprivileged short access, 0 supervisory |
| bus_addr | input | 15 | Bus address bits 15..1 |
| bus_am | input | 6 | Address modifier |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_ds_n | input | 2 | Data strobes, active low (bit 1 high byte, bit 0 low byte) |
| bus_write_n | input | 1 | 0 for write, 1 for read |
| bus_din | input | 16 | Write data from the bus |
| bus_dout | output | 16 | Read data to the bus |
| bus_dout_en | output | 1 | Enable for the read data drivers |
| bus_dtack_n | output | 1 | Data acknowledge, active low |
| status_i | input | 16 | Status word returned on a control/status read |
| adc_data_i | input | 16 | Converter result word |
| ctrl_o | output | 16 | Stored control bits |
| strobe_o | output | 16 | One-clock strobe pulses |
| ram_req_o | output | 1 | Channel RAM access request |
| ram_we_o | output | 1 | Channel RAM write |
| ram_be_o | output | 2 | Channel RAM byte lanes |
| ram_addr_o | output | 5 | Channel RAM word index |
| ram_wdata_o | output | 16 | Channel RAM write data |
| ram_rdata_i | input | 16 | Channel RAM read data |
| ram_rdy_i | input | 1 | Channel RAM grant |

## Verification
The assertions take three things for granted about the bus master:

- address, modifier, write line and write data are settled before a strobe falls;
- those lines stay steady until both strobes have risen;
- a new access starts only after the acknowledge has been released.

They also assume the arbiter keeps ram_rdy_i low until it sees a request, and drops it again once the request is withdrawn. The bench's bus tasks raise the address strobe a clock ahead of the data strobes and hold every line until release. Its RAM model answers only to a live request, after a programmable delay.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [2:0] {REG_ID, REG_CSR, REG_ADC, REG_NONE, REG_CHAN} sio_reg_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RAM, ST_ACK} sio_st_e;
  localparam logic [2:0] AM_SHORT_HI = 3'b101;
  localparam logic [1:0] AM_SHORT_LO = 2'b01;
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] stg;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= 2'b11;
      else        stg <= {stg[0], d[i]};
    end
    assign q[i] = stg[1];
  end
endmodule

// File: rtl/sio_decode.sv
module sio_decode
  import sio_pkg::*;
#(
  parameter int BASE_W = 9,
  parameter int CH_AW  = 5
) (
  input  logic [15:1]       addr,
  input  logic [5:0]        am,
  input  logic              as_n,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic              cfg_nonpriv,
  output logic              hit,
  output sio_reg_e          reg_sel,
  output logic [CH_AW-1:0]  ch_idx
);
  logic am_ok;
  assign am_ok = (am[5:3] == AM_SHORT_HI) && (am[1:0] == AM_SHORT_LO) && (am[2] == !cfg_nonpriv);
  assign hit   = !as_n && am_ok && (addr[15:7] == cfg_base);
  assign ch_idx = addr[CH_AW:1];

  always_comb begin
    if (addr[6]) reg_sel = REG_CHAN;
    else begin
      case (addr[5:1])
        5'd0:    reg_sel = REG_ID;
        5'd1:    reg_sel = REG_CSR;
        5'd2:    reg_sel = REG_ADC;
        default: reg_sel = REG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sio_csr.sv
module sio_csr #(
  parameter int          DW          = 16,
  parameter logic [15:0] STROBE_MASK = 16'hE000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    be,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] strobe_o
);
  localparam int HB = DW / 2;
  logic [DW-1:0] lane_m, ctrl_d, strobe_d;

  assign lane_m = {{HB{be[1]}}, {HB{be[0]}}};

  always_comb begin
    ctrl_d   = ctrl_o;
    strobe_d = '0;
    if (wr_en) begin
      ctrl_d   = (ctrl_o & ~lane_m) | (wdata & lane_m & ~STROBE_MASK);
      strobe_d = wdata & lane_m & STROBE_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o   <= '0;
      strobe_o <= '0;
    end else begin
      ctrl_o   <= ctrl_d;
      strobe_o <= strobe_d;
    end
  end

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_o != '0) |=> (strobe_o == '0));
  assert_ctrl_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_o));
endmodule

// File: rtl/sio_slave_if.sv
module sio_slave_if
  import sio_pkg::*;
#(
  parameter int          DW          = 16,
  parameter int          N_CH        = 32,
  parameter int          BASE_W      = 9,
  parameter logic [7:0]  ID_BYTE     = 8'h17,
  parameter logic [15:0] STROBE_MASK = 16'hE000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [BASE_W-1:0]        cfg_base,
  input  logic                     cfg_nonpriv,
  input  logic [15:1]              bus_addr,
  input  logic [5:0]               bus_am,
  input  logic                     bus_as_n,
  input  logic [1:0]               bus_ds_n,
  input  logic                     bus_write_n,
  input  logic [DW-1:0]            bus_din,
  output logic [DW-1:0]            bus_dout,
  output logic                     bus_dout_en,
  output logic                     bus_dtack_n,
  input  logic [DW-1:0]            status_i,
  input  logic [DW-1:0]            adc_data_i,
  output logic [DW-1:0]            ctrl_o,
  output logic [DW-1:0]            strobe_o,
  output logic                     ram_req_o,
  output logic                     ram_we_o,
  output logic [1:0]               ram_be_o,
  output logic [$clog2(N_CH)-1:0]  ram_addr_o,
  output logic [DW-1:0]            ram_wdata_o,
  input  logic [DW-1:0]            ram_rdata_i,
  input  logic                     ram_rdy_i
);
  localparam int CH_AW = $clog2(N_CH);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic [1:0] ds_s;
  logic       ds_act;
  sio_sync #(.W(2)) i_ds_sync (.clk(clk), .rst_n(rst_s), .d(bus_ds_n), .q(ds_s));
  assign ds_act = !(&ds_s);

  logic             hit;
  sio_reg_e         reg_sel;
  logic [CH_AW-1:0] ch_idx;
  sio_decode #(.BASE_W(BASE_W), .CH_AW(CH_AW)) i_decode (
    .addr(bus_addr), .am(bus_am), .as_n(bus_as_n), .cfg_base(cfg_base),
    .cfg_nonpriv(cfg_nonpriv), .hit(hit), .reg_sel(reg_sel), .ch_idx(ch_idx));

  sio_st_e          st_q, st_d;
  logic [DW-1:0]    rdata_q, rdata_d, reg_mux, wd_q;
  logic             rd_q, we_q, launch, csr_wr;
  logic [1:0]       be_q;
  logic [CH_AW-1:0] ch_q;

  always_comb begin
    case (reg_sel)
      REG_ID:  reg_mux = {ID_BYTE, 8'h00};
      REG_CSR: reg_mux = status_i;
      REG_ADC: reg_mux = adc_data_i;
      default: reg_mux = '0;
    endcase
  end

  always_comb begin
    st_d    = st_q;
    rdata_d = rdata_q;
    launch  = 1'b0;
    csr_wr  = 1'b0;
    case (st_q)
      ST_IDLE: if (ds_act && hit) begin
        launch = 1'b1;
        if (reg_sel == REG_CHAN) st_d = ST_RAM;
        else begin
          st_d    = ST_ACK;
          rdata_d = reg_mux;
          csr_wr  = !bus_write_n && (reg_sel == REG_CSR);
        end
      end
      ST_RAM: if (ram_rdy_i) begin
        st_d    = ST_ACK;
        rdata_d = ram_rdata_i;
      end
      ST_ACK:  if (!ds_act) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q    <= ST_IDLE;
      rdata_q <= '0;
      rd_q    <= 1'b0;
      we_q    <= 1'b0;
      be_q    <= 2'b00;
      ch_q    <= '0;
      wd_q    <= '0;
    end else begin
      st_q    <= st_d;
      rdata_q <= rdata_d;
      if (launch) begin
        rd_q <= bus_write_n;
        we_q <= !bus_write_n;
        be_q <= ~ds_s;
        ch_q <= ch_idx;
        wd_q <= bus_din;
      end
    end
  end

  sio_csr #(.DW(DW), .STROBE_MASK(STROBE_MASK)) i_csr (
    .clk(clk), .rst_n(rst_s), .wr_en(csr_wr), .be(~ds_s), .wdata(bus_din),
    .ctrl_o(ctrl_o), .strobe_o(strobe_o));

  assign bus_dtack_n = (st_q != ST_ACK);
  assign bus_dout    = rdata_q;
  assign bus_dout_en = (st_q == ST_ACK) && rd_q;
  assign ram_req_o   = (st_q == ST_RAM);
  assign ram_we_o    = (st_q == ST_RAM) && we_q;
  assign ram_be_o    = be_q;
  assign ram_addr_o  = ch_q;
  assign ram_wdata_o = wd_q;

  assert_miss_silent_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == ST_IDLE && !hit) |=> bus_dtack_n);
  assert_hold_off_R7: assert property (@(posedge clk) disable iff (!rst_s)
    (ram_req_o && !ram_rdy_i) |=> (bus_dtack_n && ram_req_o));
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (!bus_dtack_n && (&ds_s)) |=> bus_dtack_n);
  assert_dout_read_R9: assert property (@(posedge clk) disable iff (!rst_s)
    bus_dout_en |-> (!bus_dtack_n && !ram_we_o));
endmodule

// File: tb/test_sio_slave_if.sv
module test_sio_slave_if;
  localparam int   CLK_PERIOD = 62;
  localparam int   TMO        = 40;
  localparam logic [8:0]  BASE  = 9'h0A5;
  localparam logic [15:0] BADDR = {BASE, 7'h00};
  localparam logic [5:0]  AM_SUP = 6'h2D, AM_NP = 6'h29;
  localparam logic [15:0] SMASK = 16'hE000;

  logic clk = 0, rst_n = 0;
  logic [8:0] cfg_base = BASE;
  logic cfg_nonpriv = 0;
  logic [15:1] bus_addr = '0;
  logic [5:0] bus_am = '0;
  logic bus_as_n = 1, bus_write_n = 1;
  logic [1:0] bus_ds_n = 2'b11;
  logic [15:0] bus_din = '0, status_i = 16'h5A3C, adc_data_i = 16'h0ABC;
  logic [15:0] bus_dout, ctrl_o, strobe_o, ram_wdata_o;
  logic [15:0] ram_rdata_i = '0;
  logic bus_dout_en, bus_dtack_n, ram_req_o, ram_we_o;
  logic ram_rdy_i = 0;
  logic [1:0] ram_be_o;
  logic [4:0] ram_addr_o;

  sio_slave_if i_sio_slave_if (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [15:0] mem [32];
  logic [15:0] exp_mem [32];
  int rdy_delay = 2, rdy_cnt = 0, strb_cycles = 0, overlap = 0, ack_wait = 0;
  logic [15:0] strb_val;
  logic req_seen = 0;
  logic [4:0] grant_addr;
  logic last_oe;

  // RAM arbiter model
  always @(negedge clk) begin
    if (!ram_req_o) begin ram_rdy_i = 0; rdy_cnt = 0; end
    else if (!ram_rdy_i) begin
      if (rdy_cnt >= rdy_delay) begin
        ram_rdy_i = 1; grant_addr = ram_addr_o; ram_rdata_i = mem[ram_addr_o];
        if (ram_we_o) begin
          if (ram_be_o[1]) mem[ram_addr_o][15:8] = ram_wdata_o[15:8];
          if (ram_be_o[0]) mem[ram_addr_o][7:0]  = ram_wdata_o[7:0];
        end
      end else rdy_cnt++;
    end
  end

  always @(posedge clk) begin
    if (strobe_o != 0) begin strb_cycles++; strb_val = strobe_o; end
    if (ram_req_o) req_seen = 1;
    if (ram_req_o && !bus_dtack_n) overlap++;
  end

  task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [15:0] f_ctrl(logic [15:0] c, logic [15:0] d, logic [1:0] be);
    logic [15:0] m = {{8{be[1]}}, {8{be[0]}}};
    return (c & ~m) | (d & m & ~SMASK);
  endfunction

  task automatic xfer(input logic [15:0] a, input logic [5:0] am, input logic wr,
                      input logic [1:0] be, input logic [15:0] wd,
                      output logic ack, output logic [15:0] rd);
    logic rel;
    strb_cycles = 0; strb_val = 0; req_seen = 0;
    @(negedge clk);
    bus_addr = a[15:1]; bus_am = am; bus_write_n = !wr; bus_din = wd; bus_as_n = 0;
    @(negedge clk);
    bus_ds_n = ~be;
    ack = 0; ack_wait = 0;
    for (int i = 0; i < TMO; i++) begin
      @(negedge clk); ack_wait++;
      if (!bus_dtack_n) begin ack = 1; break; end
    end
    rd = bus_dout; last_oe = bus_dout_en;
    bus_ds_n = 2'b11; bus_as_n = 1;
    rel = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (bus_dtack_n) begin rel = 1; break; end
    end
    if (ack) chk(rel, "R8 release", {15'b0, bus_dtack_n}, 16'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    logic ack; logic [15:0] rd, ec;
    void'($urandom(32'd4132));
    for (int i = 0; i < 32; i++) begin mem[i] = 0; exp_mem[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1
    chk(bus_dtack_n && !bus_dout_en && !ram_req_o, "R1 bus idle",
        {13'b0, bus_dtack_n, bus_dout_en, ram_req_o}, 16'h4);
    chk(ctrl_o == 0 && strobe_o == 0, "R1 ctrl", ctrl_o | strobe_o, 16'h0);
    // R3 reads
    xfer(BADDR | 16'h00, AM_SUP, 0, 2'b11, 0, ack, rd);
    chk(ack && rd == 16'h1700, "R3 id", rd, 16'h1700);
    chk(last_oe, "R9 oe on read", {15'b0, last_oe}, 16'h1);
    xfer(BADDR | 16'h04, AM_SUP, 0, 2'b11, 0, ack, rd);
    chk(ack && rd == adc_data_i, "R3 adc", rd, adc_data_i);
    xfer(BADDR | 16'h10, AM_SUP, 0, 2'b11, 0, ack, rd);
    chk(ack && rd == 0, "R3 unmapped", rd, 16'h0);
    // R4 CSR
    ec = 0;
    xfer(BADDR | 16'h02, AM_SUP, 1, 2'b11, 16'h1234, ack, rd); ec = f_ctrl(ec, 16'h1234, 2'b11);
    chk(ack && ctrl_o == ec, "R4 csr write", ctrl_o, ec);
    chk(!last_oe, "R9 no oe on write", {15'b0, last_oe}, 16'h0);
    chk(strb_cycles == 0, "R5 no strobe", strb_cycles[15:0], 16'h0);
    xfer(BADDR | 16'h02, AM_SUP, 0, 2'b11, 0, ack, rd);
    chk(rd == status_i && ctrl_o == ec, "R4 csr read status", rd, status_i);
    xfer(BADDR | 16'h02, AM_SUP, 1, 2'b01, 16'hFFFF, ack, rd); ec = f_ctrl(ec, 16'hFFFF, 2'b01);
    chk(ctrl_o == ec, "R4 low lane", ctrl_o, ec);
    xfer(BADDR | 16'h02, AM_SUP, 1, 2'b10, 16'h0000, ack, rd); ec = f_ctrl(ec, 16'h0000, 2'b10);
    chk(ctrl_o == ec, "R4 high lane", ctrl_o, ec);
    // R5 strobes
    xfer(BADDR | 16'h02, AM_SUP, 1, 2'b11, 16'hA0F0, ack, rd); ec = f_ctrl(ec, 16'hA0F0, 2'b11);
    chk(strb_cycles == 1 && strb_val == 16'hA000, "R5 strobe pulse", strb_val, 16'hA000);
    chk(ctrl_o == ec, "R5 ctrl after strobe", ctrl_o, ec);
    xfer(BADDR | 16'h02, AM_SUP, 1, 2'b01, 16'hE000, ack, rd); ec = f_ctrl(ec, 16'hE000, 2'b01);
    chk(strb_cycles == 0, "R5 strobe lane off", strb_cycles[15:0], 16'h0);
    // R6 read-only writes
    xfer(BADDR | 16'h00, AM_SUP, 1, 2'b11, 16'hFFFF, ack, rd);
    chk(ack && ctrl_o == ec && !req_seen && strb_cycles == 0, "R6 id write", ctrl_o, ec);
    xfer(BADDR | 16'h04, AM_SUP, 1, 2'b11, 16'hFFFF, ack, rd);
    chk(ack && ctrl_o == ec && !req_seen, "R6 adc write", ctrl_o, ec);
    xfer(BADDR | 16'h12, AM_SUP, 1, 2'b11, 16'hFFFF, ack, rd);
    chk(ack && ctrl_o == ec && !req_seen, "R6 unmapped write", ctrl_o, ec);
    xfer(BADDR | 16'h00, AM_SUP, 0, 2'b11, 0, ack, rd);
    chk(rd == 16'h1700, "R6 id intact", rd, 16'h1700);
    // R2 select
    xfer(BADDR ^ 16'h0080, AM_SUP, 1, 2'b11, 16'h00FF, ack, rd);
    chk(!ack && ctrl_o == ec, "R2 base miss", {15'b0, ack}, 16'h0);
    xfer(BADDR | 16'h42, AM_NP, 1, 2'b11, 16'h1111, ack, rd);
    chk(!ack && !req_seen, "R2 am miss", {15'b0, ack}, 16'h0);
    xfer(BADDR | 16'h02, 6'h3D, 1, 2'b11, 16'h00FF, ack, rd);
    chk(!ack && ctrl_o == ec, "R2 non-short am", ctrl_o, ec);
    cfg_nonpriv = 1;
    xfer(BADDR | 16'h02, AM_NP, 1, 2'b11, 16'h0055, ack, rd); ec = f_ctrl(ec, 16'h0055, 2'b11);
    chk(ack && ctrl_o == ec, "R2 nonpriv hit", ctrl_o, ec);
    xfer(BADDR | 16'h02, AM_SUP, 1, 2'b11, 16'h00AA, ack, rd);
    chk(!ack && ctrl_o == ec, "R2 sup miss", ctrl_o, ec);
    cfg_nonpriv = 0;
    // R7 channel with long grant delay
    rdy_delay = 20; overlap = 0;
    xfer(BADDR | 16'h7E, AM_SUP, 1, 2'b11, 16'hBEEF, ack, rd); exp_mem[31] = 16'hBEEF;
    chk(ack && ack_wait > 20, "R7 held off", ack_wait[15:0], 16'd21);
    chk(grant_addr == 5'd31 && overlap == 0, "R7 addr map", {11'b0, grant_addr}, 16'd31);
    xfer(BADDR | 16'h40, AM_SUP, 1, 2'b10, 16'hC3C3, ack, rd); exp_mem[0][15:8] = 8'hC3;
    xfer(BADDR | 16'h40, AM_SUP, 0, 2'b11, 0, ack, rd);
    chk(rd == exp_mem[0] && grant_addr == 0, "R7 lane write read", rd, exp_mem[0]);
    xfer(BADDR | 16'h7E, AM_SUP, 0, 2'b11, 0, ack, rd);
    chk(rd == 16'hBEEF, "R7 read back", rd, 16'hBEEF);
    // random mix
    for (int k = 0; k < 200; k++) begin
      int op = $urandom_range(0, 3);
      logic [4:0] ch = 5'($urandom_range(0, 31));
      logic [15:0] d = 16'($urandom);
      logic [1:0] be = 2'($urandom_range(1, 3));
      rdy_delay = $urandom_range(0, 6);
      if (op == 0) begin
        xfer(BADDR | 16'h40 | {10'b0, ch, 1'b0}, AM_SUP, 1, be, d, ack, rd);
        if (be[1]) exp_mem[ch][15:8] = d[15:8];
        if (be[0]) exp_mem[ch][7:0]  = d[7:0];
        chk(ack && grant_addr == ch, "R7 random write", {11'b0, grant_addr}, {11'b0, ch});
      end else if (op == 1) begin
        xfer(BADDR | 16'h40 | {10'b0, ch, 1'b0}, AM_SUP, 0, 2'b11, 0, ack, rd);
        chk(ack && rd == exp_mem[ch], "R7 random read", rd, exp_mem[ch]);
      end else if (op == 2) begin
        xfer(BADDR | 16'h02, AM_SUP, 1, be, d, ack, rd); ec = f_ctrl(ec, d, be);
        chk(ctrl_o == ec, "R4 random csr", ctrl_o, ec);
        chk(strb_val == (d & {{8{be[1]}}, {8{be[0]}}} & SMASK), "R5 random strobe",
            strb_val, d & {{8{be[1]}}, {8{be[0]}}} & SMASK);
      end else begin
        xfer({~BASE, 7'h40 | {1'b0, ch, 1'b0}}, AM_SUP, 1, 2'b11, d, ack, rd);
        chk(!ack && !req_seen, "R2 random miss", {15'b0, ack}, 16'h0);
      end
    end
    report();
  end
endmodule